// File: doc/BRIEF.md
# PFC Supply and Output-Feedback Supervisor

This block watches two voltages for a boost power-factor controller: the controller's supply rail and the scaled feedback taken from the converter output. Both arrive as ADC samples in millivolts, qualified by a one-cycle sample strobe. Each sample updates a set of flags, and every flag uses separate set and clear thresholds so that noise near a threshold cannot make it chatter. The flags are: supply good, an over-voltage gate inhibit, a low-power disable, and a gate-permit output that combines them with an external thermal-trip input.

A ready indication tells downstream power stages that the output has come up. It is driven as an open-drain pair. It follows its own hysteresis on the feedback sample and also depends on the history of the supply rail. It cannot be released before the supply has once reached the start level. It stays released when the supply sags and the converter stops, provided the feedback is still high. It is pulled low as soon as the supply collapses below a deep floor. After such a collapse, the supply must reach the start level again before ready can be released.

All flags are registered. They change only on a clock edge at which the strobe is high, and the new values are visible from the cycle after that edge. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pfc_supervisor`

## Requirements
- R1: `supply_ok` sets on a strobed sample with `vcc_mv` >= 12000. It clears on a strobed sample with `vcc_mv` < 8500. For any value in between it holds its state.
- R2: `ovp_inhibit` sets on a strobed sample with `fb_mv` >= 2676, which is above 2675 mV. It clears when `fb_mv` < 2500 and holds otherwise.
- R3: `low_power` sets on a strobed sample with `fb_mv` < 350. It clears when `fb_mv` >= 451, which is above 450 mV, and holds otherwise.
- R4: The ready feedback state becomes high when `fb_mv` >= 2241. It becomes low when `fb_mv` < 2051 and holds in between. Ready is released only while this state is high.
- R5: Ready stays pulled low, whatever the feedback level, until a strobed `vcc_mv` >= 12000 has been seen since reset or since the last collapse.
- R6: Once released, ready stays released after `supply_ok` clears, as long as the feedback state stays high and `vcc_mv` stays >= 5000.
- R7: A strobed `vcc_mv` < 5000 pulls ready low whatever the feedback level, and it re-arms the start condition of R5.
- R8: The ready pin is an open-drain pair. `rdy_out` is always 0. `rdy_oe` = 1 pulls the pin low (not ready), and `rdy_oe` = 0 releases it (ready).
- R9: `gate_permit` equals `supply_ok` AND NOT `ovp_inhibit` AND NOT `low_power` AND NOT `therm_trip`, all taken at the same strobed edge.
- R10: The outputs change only on a clock edge with `smp_valid` = 1, and they show the new values in the following cycle. Samples presented without the strobe have no effect.
- R11: After reset, `supply_ok`, `ovp_inhibit`, `low_power` and `gate_permit` are 0, `rdy_oe` is 1 and `rdy_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample pair |
| vcc_mv | input | 16 | Supply rail sample, mV |
| fb_mv | input | 16 | Scaled output feedback sample, mV |
| therm_trip | input | 1 | Thermal shutdown flag |
| supply_ok | output | 1 | Supply above start, with hysteresis |
| ovp_inhibit | output | 1 | Over-voltage gate inhibit |
| low_power | output | 1 | Disable / low-current request |
| gate_permit | output | 1 | Combined permission to switch the gate |
| rdy_oe | output | 1 | Ready pin pull-down enable (1 = not ready) |
| rdy_out | output | 1 | Ready pin data, constant 0 |

## Verification
The hardest state to reach is a released ready pin while the supply is below the stop level. Getting there takes the right order of events. The supply first climbs to the start level while the feedback is high. It then sags into the 5 V to 8.5 V band, which clears `supply_ok` but must leave ready untouched. From there the supply drops below 5 V and recovers to the band without reaching the start level, and the bench confirms that ready stays pulled low. Threshold samples are placed one millivolt either side of every set and clear level, and the sequence includes unstrobed samples that would flip every flag.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;
  localparam int MV_W = 16;
  typedef logic [MV_W-1:0] mv_t;
endpackage

// File: rtl/pfc_hyst_cmp.sv
module pfc_hyst_cmp
  import pfc_sup_pkg::*;
#(
  parameter int SET_MV     = 1000,
  parameter int CLR_MV     = 900,
  parameter bit LOW_ACTIVE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  mv_t  sample,
  output logic state_d,
  output logic state_q
);
  localparam mv_t SET_V = mv_t'(SET_MV);
  localparam mv_t CLR_V = mv_t'(CLR_MV);

  generate
    if (LOW_ACTIVE) begin : g_low
      always_comb begin
        state_d = state_q;
        if (en) begin
          if (sample < SET_V)       state_d = 1'b1;
          else if (sample >= CLR_V) state_d = 1'b0;
        end
      end

      AST_LOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        en && (sample < SET_V) |=> state_q); // R3
      AST_LOW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        en && (sample >= CLR_V) |=> !state_q); // R3
    end else begin : g_high
      always_comb begin
        state_d = state_q;
        if (en) begin
          if (sample >= SET_V)     state_d = 1'b1;
          else if (sample < CLR_V) state_d = 1'b0;
        end
      end

      AST_HIGH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        en && (sample >= SET_V) |=> state_q); // R1 R2 R4
      AST_HIGH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        en && (sample < CLR_V) |=> !state_q); // R1 R2 R4
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_d;
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q)); // R10
endmodule

// File: rtl/pfc_rdy_track.sv
module pfc_rdy_track
  import pfc_sup_pkg::*;
#(
  parameter int START_MV    = 12000,
  parameter int COLLAPSE_MV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  mv_t  vcc,
  input  logic fb_hi_d,
  output logic rdy_q
);
  localparam mv_t START_V    = mv_t'(START_MV);
  localparam mv_t COLLAPSE_V = mv_t'(COLLAPSE_MV);

  logic start_q, start_d, rdy_d, collapse;

  assign collapse = (vcc < COLLAPSE_V);

  always_comb begin
    start_d = start_q;
    rdy_d   = rdy_q;
    if (en) begin
      if (collapse)            start_d = 1'b0;
      else if (vcc >= START_V) start_d = 1'b1;
      rdy_d = start_d & fb_hi_d & ~collapse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      rdy_q   <= rdy_d;
    end
  end

  AST_RDY_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_n)
    en && collapse |=> !rdy_q); // R7
  AST_RDY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    en && !start_q && (vcc < START_V) |=> !rdy_q); // R5
endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int START_MV    = 12000,
  parameter int STOP_MV     = 8500,
  parameter int COLLAPSE_MV = 5000,
  parameter int OVP_SET_MV  = 2676,
  parameter int OVP_CLR_MV  = 2500,
  parameter int DIS_SET_MV  = 350,
  parameter int DIS_CLR_MV  = 451,
  parameter int RDY_SET_MV  = 2241,
  parameter int RDY_CLR_MV  = 2051
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [MV_W-1:0]     vcc_mv,
  input  logic [MV_W-1:0]     fb_mv,
  input  logic                therm_trip,
  output logic                supply_ok,
  output logic                ovp_inhibit,
  output logic                low_power,
  output logic                gate_permit,
  output logic                rdy_oe,
  output logic                rdy_out
);
  logic rst_meta, rst_sync_n;
  logic sup_d, ovp_d, dis_d, rfb_d, rfb_q, rdy_q;
  logic permit_d, permit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pfc_hyst_cmp #(.SET_MV(START_MV), .CLR_MV(STOP_MV), .LOW_ACTIVE(1'b0)) u_sup (
    .clk(clk), .rst_n(rst_sync_n), .en(smp_valid), .sample(vcc_mv),
    .state_d(sup_d), .state_q(supply_ok));

  pfc_hyst_cmp #(.SET_MV(OVP_SET_MV), .CLR_MV(OVP_CLR_MV), .LOW_ACTIVE(1'b0)) u_ovp (
    .clk(clk), .rst_n(rst_sync_n), .en(smp_valid), .sample(fb_mv),
    .state_d(ovp_d), .state_q(ovp_inhibit));

  pfc_hyst_cmp #(.SET_MV(DIS_SET_MV), .CLR_MV(DIS_CLR_MV), .LOW_ACTIVE(1'b1)) u_dis (
    .clk(clk), .rst_n(rst_sync_n), .en(smp_valid), .sample(fb_mv),
    .state_d(dis_d), .state_q(low_power));

  pfc_hyst_cmp #(.SET_MV(RDY_SET_MV), .CLR_MV(RDY_CLR_MV), .LOW_ACTIVE(1'b0)) u_rfb (
    .clk(clk), .rst_n(rst_sync_n), .en(smp_valid), .sample(fb_mv),
    .state_d(rfb_d), .state_q(rfb_q));

  pfc_rdy_track #(.START_MV(START_MV), .COLLAPSE_MV(COLLAPSE_MV)) u_rdy (
    .clk(clk), .rst_n(rst_sync_n), .en(smp_valid), .vcc(vcc_mv),
    .fb_hi_d(rfb_d), .rdy_q(rdy_q));

  always_comb begin
    permit_d = permit_q;
    if (smp_valid) permit_d = sup_d & ~ovp_d & ~dis_d & ~therm_trip;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) permit_q <= 1'b0;
    else             permit_q <= permit_d;
  end

  assign gate_permit = permit_q;
  assign rdy_oe      = ~rdy_q;
  assign rdy_out     = 1'b0;

  AST_PERMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gate_permit |-> supply_ok && !ovp_inhibit && !low_power); // R9
  AST_PERMIT_THERM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    smp_valid && therm_trip |=> !gate_permit); // R9
  AST_RDY_FB_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rdy_oe |-> rfb_q); // R4
  AST_RDY_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rdy_out); // R8
endmodule

// File: tb/pfc_supervisor_bench.sv
module pfc_supervisor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] vcc_mv = '0;
  logic [15:0] fb_mv = '0;
  logic        therm_trip = 1'b0;
  logic        supply_ok, ovp_inhibit, low_power, gate_permit, rdy_oe, rdy_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  bit m_sup, m_ovp, m_dis, m_rfb, m_start, m_rdy, m_perm;

  always #10 clk = ~clk;

  pfc_supervisor u_pfc_supervisor (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .vcc_mv(vcc_mv),
    .fb_mv(fb_mv), .therm_trip(therm_trip), .supply_ok(supply_ok),
    .ovp_inhibit(ovp_inhibit), .low_power(low_power), .gate_permit(gate_permit),
    .rdy_oe(rdy_oe), .rdy_out(rdy_out));

  function automatic logic [5:0] outs();
    return {supply_ok, ovp_inhibit, low_power, gate_permit, rdy_oe, rdy_out};
  endfunction

  task automatic step(input int v, input int f, input bit th, input bit vld, input string tag);
    item_t it;
    @(negedge clk);
    vcc_mv = 16'(v); fb_mv = 16'(f); therm_trip = th; smp_valid = vld;
    if (vld) begin
      if (v >= 12000) m_sup = 1; else if (v < 8500) m_sup = 0;
      if (f >= 2676) m_ovp = 1; else if (f < 2500) m_ovp = 0;
      if (f < 350) m_dis = 1; else if (f >= 451) m_dis = 0;
      if (f >= 2241) m_rfb = 1; else if (f < 2051) m_rfb = 0;
      if (v < 5000) m_start = 0; else if (v >= 12000) m_start = 1;
      m_rdy  = m_start && m_rfb && (v >= 5000);
      m_perm = m_sup && !m_ovp && !m_dis && !th;
    end
    it.exp = {m_sup, m_ovp, m_dis, m_perm, !m_rdy, 1'b0};
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (outs() !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b (ok,ovp,lp,perm,oe,out)", it.tag, outs(), it.exp);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    n_cmp++;
    if (outs() !== 6'b000010) begin
      n_bad++;
      $display("FAIL R11: got %b expected %b", outs(), 6'b000010);
    end
    // R10 unstrobed samples that would flip every flag
    step(13000, 300, 1'b0, 1'b0, "R10");
    step(13000, 2800, 1'b0, 1'b0, "R10");
    // R5 feedback high but supply never at start
    step(11000, 2400, 1'b0, 1'b1, "R5");
    step(11999, 2400, 1'b0, 1'b1, "R5");
    // R1 set at start level, ready released too
    step(12000, 2400, 1'b0, 1'b1, "R1");
    step(9000, 2400, 1'b0, 1'b1, "R1");
    step(8500, 2400, 1'b0, 1'b1, "R1");
    // R6 supply sags below stop, ready remains
    step(8499, 2400, 1'b0, 1'b1, "R6");
    step(5000, 2400, 1'b0, 1'b1, "R6");
    // R7 collapse, then recovery without start
    step(4999, 2400, 1'b0, 1'b1, "R7");
    step(7000, 2400, 1'b0, 1'b1, "R7");
    step(12500, 2400, 1'b0, 1'b1, "R7");
    // R4 feedback hysteresis
    step(13000, 2100, 1'b0, 1'b1, "R4");
    step(13000, 2051, 1'b0, 1'b1, "R4");
    step(13000, 2050, 1'b0, 1'b1, "R4");
    step(13000, 2240, 1'b0, 1'b1, "R4");
    step(13000, 2241, 1'b0, 1'b1, "R4");
    // R2 over-voltage
    step(13000, 2675, 1'b0, 1'b1, "R2");
    step(13000, 2676, 1'b0, 1'b1, "R2");
    step(13000, 2500, 1'b0, 1'b1, "R2");
    step(13000, 2499, 1'b0, 1'b1, "R2");
    // R9 thermal trip and its release
    step(13000, 2400, 1'b1, 1'b1, "R9");
    step(13000, 2400, 1'b1, 1'b0, "R10");
    step(13000, 2400, 1'b0, 1'b1, "R9");
    // R3 disable hysteresis
    step(13000, 350, 1'b0, 1'b1, "R3");
    step(13000, 349, 1'b0, 1'b1, "R3");
    step(13000, 450, 1'b0, 1'b1, "R3");
    step(13000, 451, 1'b0, 1'b1, "R3");
    // R8 pin data stays 0 in both ready states
    step(13000, 2400, 1'b0, 1'b1, "R8");
    step(13000, 100, 1'b0, 1'b1, "R8");
    step(13000, 100, 1'b0, 1'b0, "R8");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule